// File: doc/BRIEF.md
# E3 Nibble-Parallel Transmit Timing Generator

This block paces the transmit terminal interface of an E3 framer when payload arrives four bits at a time. It counts nibble clocks across each outbound frame of 1060 nibble slots. It raises a frame-end strobe during the final slot, which tells the terminal equipment to present slot 0 of the next frame on the following clock. It also raises an overhead indicator on the slots that the framer fills with overhead bytes rather than terminal payload.

Every nibble that the block accepts is registered, together with its slot number and a one-bit overhead tag, for the downstream framer datapath. The whole block runs only when the nibble interface is selected and the timing-reference field selects the local transmit reference. In any other configuration it stays idle and ignores the terminal.

Top module: `e3_nib_tx_timer`

## Requirements
- R1: While `rst` is high, the slot counter is forced to 0, `frame_end_o`, `ovh_ind_o`, `nib_out`, `nib_ovh` and `nib_slot` are all 0. The clock edge after `rst` falls processes slot 0.
- R2: While enabled, the slot number advances by one on each clock from 0 up to 1059 and then returns to 0.
- R3: `frame_end_o` is high for exactly one clock per frame, during slot 1059, and is low in every other slot.
- R4: `ovh_ind_o` is high during slots 0, 1, 2 and 3 of every frame.
- R5: Apart from slots 0 to 3, `ovh_ind_o` is high only in five 2-slot windows that start at the parameter slots. The defaults are 176, 352, 528, 704 and 880, so the windows cover 176-177, 352-353, 528-529, 704-705 and 880-881. That gives 14 overhead slots per frame, and slot 1059 is payload.
- R6: The block is enabled only when `nib_if_sel` is 1 and `tref_sel` equals 2'b00. Any other value of `tref_sel` disables it.
- R7: While disabled, the slot counter holds, both `frame_end_o` and `ovh_ind_o` are low, and `nib_out`, `nib_ovh` and `nib_slot` keep their values, so `nib_in` is ignored.
- R8: On each enabled clock edge, `nib_out` takes `nib_in`, `nib_slot` takes the current slot number, and `nib_ovh` takes 1 for an overhead slot and 0 for a payload slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst | input | 1 | Synchronous active-high reset |
| nib_if_sel | input | 1 | Nibble-parallel interface selected |
| tref_sel | input | 2 | Timing-reference select; 2'b00 enables the block |
| nib_in | input | 4 | Nibble from the terminal equipment |
| frame_end_o | output | 1 | High during the last slot of the frame |
| ovh_ind_o | output | 1 | High during overhead slots |
| nib_out | output | 4 | Registered accepted nibble |
| nib_ovh | output | 1 | Registered tag: 1 = overhead, 0 = payload |
| nib_slot | output | 11 | Registered slot number of `nib_out` |

## Verification
A slot counter that is off by even one position moves every overhead window and the frame-end strobe. It also changes the value of `nib_slot`, which shows the error one clock after the faulty edge. A counter that wraps at the wrong value changes the number of overhead slots or frame-end strobes per frame, and this appears within one frame of 1060 clocks. A counter that moves while the block is disabled shows as a changed `nib_slot` or a shifted overhead window on the first enabled clock after the block is switched back on.

// File: rtl/e3_nib_tx_timer.sv
module e3_nib_tx_timer #(
  parameter int unsigned FRAME_NIBS = 1060,
  parameter int unsigned HEAD_NIBS  = 4,
  parameter int unsigned PAIR_CNT   = 5,
  parameter int unsigned PAIR_NIBS  = 2,
  parameter int unsigned PAIR_START [PAIR_CNT] = '{176, 352, 528, 704, 880},
  localparam int unsigned SW = $clog2(FRAME_NIBS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nib_if_sel,
  input  logic [1:0]    tref_sel,
  input  logic [3:0]    nib_in,
  output logic          frame_end_o,
  output logic          ovh_ind_o,
  output logic [3:0]    nib_out,
  output logic          nib_ovh,
  output logic [SW-1:0] nib_slot
);

  logic [SW-1:0]       slot_q;
  logic [PAIR_CNT-1:0] pair_hit;

  wire mode_on = nib_if_sel && (tref_sel == 2'b00);
  wire at_last = (slot_q == SW'(FRAME_NIBS - 1));

  for (genvar g = 0; g < PAIR_CNT; g++) begin : g_pair
    assign pair_hit[g] = (slot_q >= SW'(PAIR_START[g])) &&
                         (slot_q <  SW'(PAIR_START[g] + PAIR_NIBS));
  end

  wire in_ovh = (slot_q < SW'(HEAD_NIBS)) || (|pair_hit);

  assign frame_end_o = !rst && mode_on && at_last;
  assign ovh_ind_o   = !rst && mode_on && in_ovh;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= '0;
      nib_out  <= '0;
      nib_ovh  <= 1'b0;
      nib_slot <= '0;
    end else if (mode_on) begin
      slot_q   <= at_last ? '0 : slot_q + 1'b1;
      nib_out  <= nib_in;
      nib_ovh  <= in_ovh;
      nib_slot <= slot_q;
    end
  end

endmodule

module e3_nib_tx_timer_chk #(
  parameter int unsigned FRAME_NIBS = 1060,
  parameter int unsigned OVH_TOTAL  = 14,
  parameter int unsigned HEAD_NIBS  = 4,
  localparam int unsigned SW = $clog2(FRAME_NIBS)
) (
  input logic          clk,
  input logic          rst,
  input logic          nib_if_sel,
  input logic [1:0]    tref_sel,
  input logic [3:0]    nib_in,
  input logic          frame_end_o,
  input logic          ovh_ind_o,
  input logic [3:0]    nib_out,
  input logic          nib_ovh,
  input logic [SW-1:0] nib_slot,
  input logic [SW-1:0] slot_q
);

  wire en = nib_if_sel && (tref_sel == 2'b00);
  logic [SW-1:0] oh_cnt;

  always_ff @(posedge clk) begin
    if (rst) oh_cnt <= '0;
    else if (en) oh_cnt <= frame_end_o ? '0 : oh_cnt + SW'(ovh_ind_o);
  end

  AST_RESET_LOW: assert property (@(posedge clk) rst |-> !frame_end_o && !ovh_ind_o); // R1
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot_q < SW'(FRAME_NIBS)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    en && frame_end_o |=> slot_q == '0); // R2
  AST_END_SLOT: assert property (@(posedge clk) disable iff (rst)
    frame_end_o |-> slot_q == SW'(FRAME_NIBS - 1)); // R3
  AST_HEAD_OVH: assert property (@(posedge clk) disable iff (rst)
    en && slot_q < SW'(HEAD_NIBS) |-> ovh_ind_o); // R4
  AST_OVH_TOTAL: assert property (@(posedge clk) disable iff (rst)
    en && frame_end_o |-> oh_cnt == SW'(OVH_TOTAL) && !ovh_ind_o); // R5
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |-> !frame_end_o && !ovh_ind_o); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(slot_q) && $stable(nib_out) && $stable(nib_slot) && $stable(nib_ovh)); // R7
  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    en |=> nib_out == $past(nib_in) && nib_slot == $past(slot_q) && nib_ovh == $past(ovh_ind_o)); // R8

endmodule

bind e3_nib_tx_timer e3_nib_tx_timer_chk #(
  .FRAME_NIBS(FRAME_NIBS),
  .OVH_TOTAL(HEAD_NIBS + PAIR_CNT * PAIR_NIBS),
  .HEAD_NIBS(HEAD_NIBS)
) chk_i (
  .clk(clk), .rst(rst), .nib_if_sel(nib_if_sel), .tref_sel(tref_sel),
  .nib_in(nib_in), .frame_end_o(frame_end_o), .ovh_ind_o(ovh_ind_o),
  .nib_out(nib_out), .nib_ovh(nib_ovh), .nib_slot(nib_slot), .slot_q(slot_q)
);

// File: tb/e3_nib_tx_timer_tb.sv
module e3_nib_tx_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nib_if_sel = 1'b1;
  logic [1:0]  tref_sel = 2'b00;
  logic [3:0]  nib_in = 4'h0;
  logic        frame_end_o, ovh_ind_o, nib_ovh;
  logic [3:0]  nib_out;
  logic [10:0] nib_slot;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  e3_nib_tx_timer dut_i (
    .clk(clk), .rst(rst), .nib_if_sel(nib_if_sel), .tref_sel(tref_sel),
    .nib_in(nib_in), .frame_end_o(frame_end_o), .ovh_ind_o(ovh_ind_o),
    .nib_out(nib_out), .nib_ovh(nib_ovh), .nib_slot(nib_slot)
  );

  // {slot[10:0], expected overhead, expected frame end}
  localparam logic [12:0] VEC [12] = '{
    {11'd0,    1'b1, 1'b0}, {11'd3,    1'b1, 1'b0}, {11'd4,    1'b0, 1'b0},
    {11'd175,  1'b0, 1'b0}, {11'd176,  1'b1, 1'b0}, {11'd177,  1'b1, 1'b0},
    {11'd178,  1'b0, 1'b0}, {11'd528,  1'b1, 1'b0}, {11'd881,  1'b1, 1'b0},
    {11'd882,  1'b0, 1'b0}, {11'd1058, 1'b0, 1'b0}, {11'd1059, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_ovh(input int s);
    bit r = (s < 4);
    for (int k = 1; k <= 5; k++) if (s >= 176 * k && s < 176 * k + 2) r = 1'b1;
    return r;
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int oh_cnt, fe_cnt, fe_slot;
    int prev_slot;
    logic [3:0] prev_nib, held_nib;
    logic prev_ovh;
    logic [10:0] held_slot;

    repeat (3) @(posedge clk);
    step();
    chk(frame_end_o == 0, "R1 frame_end in reset", frame_end_o, 0);
    chk(ovh_ind_o == 0, "R1 ovh_ind in reset", ovh_ind_o, 0);
    chk(nib_slot == 0 && nib_out == 0 && nib_ovh == 0, "R1 registered outputs in reset", nib_slot, 0);

    rst = 1'b0;
    #1;
    prev_slot = -1;
    prev_nib = '0;
    prev_ovh = 1'b0;
    for (int f = 0; f < 2; f++) begin
      oh_cnt = 0; fe_cnt = 0; fe_slot = -1;
      for (int s = 0; s < 1060; s++) begin
        for (int v = 0; v < 12; v++) begin
          if (int'(VEC[v][12:2]) == s) begin
            chk(ovh_ind_o == VEC[v][1], $sformatf("R4/R5 ovh at slot %0d", s), ovh_ind_o, VEC[v][1]);
            chk(frame_end_o == VEC[v][0], $sformatf("R3 frame_end at slot %0d", s), frame_end_o, VEC[v][0]);
          end
        end
        if (ovh_ind_o !== exp_ovh(s))
          chk(0, $sformatf("R5 ovh pattern slot %0d", s), ovh_ind_o, exp_ovh(s));
        if (ovh_ind_o) oh_cnt++;
        if (frame_end_o) begin fe_cnt++; fe_slot = s; end
        if (prev_slot >= 0 && (nib_out !== prev_nib || int'(nib_slot) != prev_slot || nib_ovh !== prev_ovh))
          chk(0, $sformatf("R8 capture of slot %0d", prev_slot), nib_slot, prev_slot);
        prev_slot = s;
        prev_nib = 4'(s * 3 + f);
        prev_ovh = exp_ovh(s);
        nib_in = prev_nib;
        step();
      end
      chk(oh_cnt == 14, "R5 overhead slots per frame", oh_cnt, 14);
      chk(fe_cnt == 1, "R3 frame_end pulses per frame", fe_cnt, 1);
      chk(fe_slot == 1059, "R3 frame_end slot", fe_slot, 1059);
      chk(int'(nib_slot) == 1059 && nib_out == prev_nib, "R8 last capture", nib_slot, 1059);
    end
    chk(ovh_ind_o == 1 && frame_end_o == 0, "R2 wrap to slot 0", ovh_ind_o, 1);

    step(); step();
    chk(int'(nib_slot) == 1, "R2 slot advance", nib_slot, 1);
    nib_if_sel = 1'b0;
    #1;
    held_nib = nib_out;
    held_slot = nib_slot;
    chk(ovh_ind_o == 0 && frame_end_o == 0, "R7 outputs low when disabled", ovh_ind_o, 0);
    nib_in = ~held_nib;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(nib_out == held_nib && nib_slot == held_slot, "R7 nibble ignored", nib_out, held_nib);
      chk(ovh_ind_o == 0, "R7 ovh low when disabled", ovh_ind_o, 0);
    end
    nib_if_sel = 1'b1;
    tref_sel = 2'b10;
    #1;
    chk(ovh_ind_o == 0, "R6 tref_sel 2'b10 disables", ovh_ind_o, 0);
    tref_sel = 2'b01;
    step();
    chk(ovh_ind_o == 0 && nib_slot == held_slot, "R6 tref_sel 2'b01 disables", nib_slot, held_slot);
    tref_sel = 2'b00;
    #1;
    chk(ovh_ind_o == 1, "R6 enabled again, slot 2 overhead", ovh_ind_o, 1);
    step();
    chk(int'(nib_slot) == 2 && nib_ovh == 1, "R7 counter held while disabled", nib_slot, 2);

    for (int i = 0; i < 10; i++) step();
    rst = 1'b1;
    #1;
    chk(ovh_ind_o == 0 && frame_end_o == 0, "R1 outputs low during reset", ovh_ind_o, 0);
    step();
    rst = 1'b0;
    nib_in = 4'h9;
    #1;
    chk(ovh_ind_o == 1, "R1 slot 0 after reset", ovh_ind_o, 1);
    step();
    chk(int'(nib_slot) == 0 && nib_out == 4'h9 && nib_ovh == 1, "R1 first edge after reset is slot 0", nib_slot, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule